// File: doc/BRIEF.md
# I2C Controller Byte Engine

This block is the bit-level core of a single-controller I2C port. A host hands it one command at a time: open a transfer (START, which becomes a repeated START when the engine already holds the bus), close it (STOP), send a byte, or receive a byte with an acknowledge or a not-acknowledge. The engine makes every SCL pulse itself, including the ninth pulse used for the acknowledge. The SCL low and high phases come from a programmable divider. Both bus lines are driven open-drain: an output enable of 1 pulls the wire low, and 0 lets it float high.

After each written byte the engine reports the acknowledge level it sampled. The host can then decide between STOP and repeated START when a target refuses. Targets may stretch the clock. The engine times a high phase only after it reads SCL back as high, so a target holding SCL low simply holds the engine in place. Between commands the engine keeps SCL low, which keeps the bus owned until STOP.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, sclOe, sdaOe, busy, done and ackRcvd are all 0.
- R2: cmdOp=1 (START) while the bus is released pulls SDA low while SCL is high. SCL is pulled low after at least cfgDiv cycles and stays low until the next command.
- R3: cmdOp=1 while the engine holds SCL low is a repeated START. SDA is released during a low phase, SCL is released, and SDA then falls while SCL is high. No STOP appears on the bus.
- R4: cmdOp=2 (STOP) drives SDA low in a low phase and releases SCL. It then releases SDA while SCL is high, and both lines stay released afterwards.
- R5: cmdOp=3 (WRITE) sends cmdData on eight pulses, most significant bit first. Outside START and STOP, SDA changes only while SCL is low.
- R6: On the ninth pulse of a WRITE, the engine releases SDA and puts the level sampled at the end of the high phase on ackRcvd (0 = ACK, 1 = NACK). It then goes idle and waits for the host's next command.
- R7: cmdOp=4 (READ) shifts eight bits into rxData, most significant bit first. On the ninth pulse SDA is driven low when cmdLast=0 and released when cmdLast=1.
- R8: An SCL high phase is timed only from the point where SCL is read back as high. It lasts at least cfgDiv cycles, even when a target stretches the low phase.
- R9: busy is high from command acceptance until completion, and done then pulses for exactly one cycle. cmdValid is ignored while busy.
- R10: cmdOp values 0, 5, 6 and 7 are ignored: busy stays low and neither bus line moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDiv | input | DIV_W | Phase length in clock cycles (at least 1) |
| cmdValid | input | 1 | Command strobe, taken when busy is low |
| cmdOp | input | 3 | 1 START, 2 STOP, 3 WRITE, 4 READ |
| cmdData | input | BYTE_W | Byte to send for WRITE |
| cmdLast | input | 1 | READ: 1 sends NACK on the ninth pulse |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rxData | output | BYTE_W | Last byte received |
| ackRcvd | output | 1 | Ninth-pulse level of the last WRITE |
| sclIn | input | 1 | SCL wire level |
| sdaIn | input | 1 | SDA wire level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The bench plays a target on a wired-AND bus and watches every clock for SDA moving while SCL is high, and for high phases shorter than the divider. Writes use bit patterns with alternating, clustered and edge-heavy ones and zeros, so that bit-order and shift errors show up. The target acknowledges some writes and refuses others, which tells a sampled acknowledge from a constant one. Reads run with both cmdLast values. One write runs with the target stretching every low phase, which separates waiting on the wire from waiting on the timer. Runs at two divider settings, together with repeated START, STOP, illegal opcodes and a command injected while busy, cover the framing and handshake corners.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } engOp_e;

  // strobes and mode levels from control to datapath
  typedef struct packed {
    logic cntLoad;     // restart the phase counter
    logic loadTx;      // capture the byte, clear the slot counter
    logic setSlotSda;  // apply this slot's SDA level (SCL low)
    logic sampleBit;   // take SDA at the end of a data high phase
    logic sclLow;      // pull SCL low
    logic sclRelease;  // let SCL float
    logic sdaLow;      // condition edge: SDA falls with SCL high
    logic sdaHigh;     // condition edge: SDA rises with SCL high
    logic opWrite;
    logic opRead;
    logic opStop;
    logic lastByte;
  } engCtl_t;

endpackage

// File: rtl/i2c_eng_dp.sv
module i2c_eng_dp
  import i2c_eng_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  engCtl_t           ctl,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              sdaIn,
  output logic              cntZero,
  output logic              slotLast,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rxData,
  output logic              ackBit
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [DIV_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic              slotDrive;

  assign cntZero  = (phaseCnt == '0);
  assign slotLast = (bitCnt == CNT_W'(BYTE_W));
  assign rxData   = rxShift;

  // phase timer
  always_ff @(posedge clk) begin
    if (!rstN)               phaseCnt <= '0;
    else if (ctl.cntLoad)    phaseCnt <= cfgDiv - DIV_W'(1);
    else if (phaseCnt != '0) phaseCnt <= phaseCnt - DIV_W'(1);
  end

  // slot counter and shifters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      txShift <= '0;
      rxShift <= '0;
      ackBit  <= 1'b0;
    end else if (ctl.loadTx) begin
      bitCnt  <= '0;
      txShift <= txByte;
    end else if (ctl.sampleBit) begin
      bitCnt <= bitCnt + CNT_W'(1);
      if (!slotLast) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
        rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
      end else if (ctl.opWrite) begin
        ackBit <= sdaIn;
      end
    end
  end

  // SDA level wanted for the current slot's low phase
  always_comb begin
    if (ctl.opWrite)     slotDrive = slotLast ? 1'b0 : !txShift[BYTE_W-1];
    else if (ctl.opRead) slotDrive = slotLast ? !ctl.lastByte : 1'b0;
    else                 slotDrive = ctl.opStop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      if (ctl.sclLow)          sclOe <= 1'b1;
      else if (ctl.sclRelease) sclOe <= 1'b0;
      if (ctl.sdaLow)          sdaOe <= 1'b1;
      else if (ctl.sdaHigh)    sdaOe <= 1'b0;
      else if (ctl.setSlotSda) sdaOe <= slotDrive;
    end
  end

  // SDA may move with SCL released only for a START or STOP edge (R5)
  assert_sda_moves_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && !$past(sclOe) && !$stable(sdaOe)) |-> $past(ctl.sdaLow || ctl.sdaHigh));

  // acknowledge pulse of a write leaves SDA to the target (R6)
  assert_write_ack_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sampleBit && ctl.opWrite && slotLast) |-> !sdaOe);

  // acknowledge pulse of a read carries ACK or NACK as requested (R7)
  assert_read_ack_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sampleBit && ctl.opRead && slotLast) |-> (sdaOe == !ctl.lastByte));

endmodule

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       cmdLast,
  input  logic       cntZero,
  input  logic       slotLast,
  input  logic       sclIn,
  output engCtl_t    ctl,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOWSET, S_LOW, S_RISE, S_HIGH, S_COND
  } engState_e;

  engState_e state, stateNext;
  engOp_e    opReg;
  logic      lastReg;
  logic      holding, holdNext;
  logic      doneNext;
  logic      cmdOk;
  engOp_e    cmdOpE;

  assign cmdOpE = engOp_e'(cmdOp);
  assign cmdOk  = cmdValid && (cmdOpE == OP_START || cmdOpE == OP_STOP ||
                               cmdOpE == OP_WRITE || cmdOpE == OP_READ);
  assign busy   = (state != S_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.opWrite  = (opReg == OP_WRITE);
    ctl.opRead   = (opReg == OP_READ);
    ctl.opStop   = (opReg == OP_STOP);
    ctl.lastByte = lastReg;
    stateNext    = state;
    holdNext     = holding;
    doneNext     = 1'b0;
    unique case (state)
      S_IDLE: if (cmdOk) begin
        ctl.loadTx = 1'b1;
        if (cmdOpE == OP_START && !holding) begin
          ctl.sdaLow  = 1'b1;
          ctl.cntLoad = 1'b1;
          stateNext   = S_COND;
        end else begin
          ctl.sclLow = 1'b1;
          stateNext  = S_LOWSET;
        end
      end
      S_LOWSET: begin
        ctl.setSlotSda = 1'b1;
        ctl.cntLoad    = 1'b1;
        stateNext      = S_LOW;
      end
      S_LOW: if (cntZero) begin
        ctl.sclRelease = 1'b1;
        stateNext      = S_RISE;
      end
      S_RISE: if (sclIn) begin
        ctl.cntLoad = 1'b1;
        stateNext   = S_HIGH;
      end
      S_HIGH: if (cntZero) begin
        if (opReg == OP_START) begin
          ctl.sdaLow  = 1'b1;
          ctl.cntLoad = 1'b1;
          stateNext   = S_COND;
        end else if (opReg == OP_STOP) begin
          ctl.sdaHigh = 1'b1;
          ctl.cntLoad = 1'b1;
          stateNext   = S_COND;
        end else begin
          ctl.sampleBit = 1'b1;
          ctl.sclLow    = 1'b1;
          if (slotLast) begin
            stateNext = S_IDLE;
            doneNext  = 1'b1;
          end else begin
            stateNext = S_LOWSET;
          end
        end
      end
      S_COND: if (cntZero) begin
        if (opReg == OP_START) begin
          ctl.sclLow = 1'b1;
          holdNext   = 1'b1;
        end else begin
          holdNext = 1'b0;
        end
        stateNext = S_IDLE;
        doneNext  = 1'b1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= OP_NONE;
      lastReg <= 1'b0;
      holding <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      holding <= holdNext;
      done    <= doneNext;
      if (state == S_IDLE && cmdOk) begin
        opReg   <= cmdOpE;
        lastReg <= cmdLast;
      end
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_cmd_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> (opReg == $past(opReg)));

  assert_rise_waits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RISE && !sclIn) |=> (state == S_RISE));

  assert_bad_op_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cmdValid && !cmdOk) |=> !busy);

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdLast,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rxData,
  output logic              ackRcvd,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe
);

  engCtl_t ctl;
  logic    cntZero;
  logic    slotLast;

  i2c_eng_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdLast  (cmdLast),
    .cntZero  (cntZero),
    .slotLast (slotLast),
    .sclIn    (sclIn),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  i2c_eng_dp #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cfgDiv   (cfgDiv),
    .txByte   (cmdData),
    .sdaIn    (sdaIn),
    .cntZero  (cntZero),
    .slotLast (slotLast),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe),
    .rxData   (rxData),
    .ackBit   (ackRcvd)
  );

  assert_reset_released_R1: assert property (@(posedge clk)
    !rstN |=> (!sclOe && !sdaOe && !done));

endmodule

// File: tb/tb_i2c_byte_engine.sv
module tb_i2c_byte_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgDiv = 16'd4;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [7:0]  cmdData = 8'h00;
  logic        cmdLast = 1'b0;
  logic        busy, done, ackRcvd, sclOe, sdaOe;
  logic [7:0]  rxData;

  // target model state
  logic        tgtSclHold = 1'b0;
  logic        tgtSdaDrv;
  logic        readMode = 1'b0;
  logic        tgtAck = 1'b1;
  logic [7:0]  tgtByte = 8'h00;
  int          stretchLen = 0;
  int          holdCnt = 0;
  int          bitPos = 0;
  int          drvPos = 0;
  logic [7:0]  shReg = 8'h00;
  logic        masterAck = 1'b0;
  int          startCnt = 0;
  int          stopCnt = 0;
  int          highLen = 1000;
  logic        prevScl = 1'b1;
  logic        prevSda = 1'b1;
  logic        condAllowed = 1'b0;
  int          stretchEvents = 0;

  int compared = 0;
  int mismatched = 0;

  wire sclLine = !sclOe && !tgtSclHold;
  wire sdaLine = !sdaOe && !tgtSdaDrv;

  always #4 clk = ~clk;

  i2c_byte_engine dut (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdLast(cmdLast), .busy(busy), .done(done), .rxData(rxData),
    .ackRcvd(ackRcvd), .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  always_comb begin
    if (readMode && drvPos < 8)        tgtSdaDrv = !tgtByte[7 - drvPos];
    else if (!readMode && drvPos == 8) tgtSdaDrv = tgtAck;
    else                               tgtSdaDrv = 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target and bus watcher, sampled away from the active edge
  always @(negedge clk) begin
    logic curScl, curSda;
    curScl = sclLine;
    curSda = sdaLine;
    if (rstN) begin
      if (prevScl && curScl) begin
        compared++;
        if (prevSda != curSda && !condAllowed) begin
          mismatched++;
          $display("FAIL R5 SDA moved with SCL high actual=%0d expected=%0d", curSda, prevSda);
        end
        if (prevSda && !curSda) begin startCnt++; bitPos = 0; drvPos = 0; end
        if (!prevSda && curSda) begin stopCnt++;  bitPos = 0; drvPos = 0; end
        highLen++;
      end
      if (!prevScl && curScl) begin
        highLen = 1;
        if (bitPos < 8) shReg = {shReg[6:0], curSda};
        else if (bitPos == 8) masterAck = curSda;
        bitPos++;
      end
      if (prevScl && !curScl) begin
        check(highLen >= int'(cfgDiv), "R8 high phase length", highLen, cfgDiv);
        if (bitPos == 9) bitPos = 0;
        drvPos = bitPos;
        if (stretchLen > 0) begin
          tgtSclHold = 1'b1;
          holdCnt = stretchLen;
          stretchEvents++;
        end
      end else if (tgtSclHold) begin
        holdCnt--;
        if (holdCnt <= 0) tgtSclHold = 1'b0;
      end
    end
    prevScl = curScl;
    prevSda = curSda;
  end

  task automatic doCmd(input logic [2:0] op, input logic [7:0] d, input logic last,
                       output int doneCycles);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmdOp = op; cmdData = d; cmdLast = last; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    doneCycles = 0;
    while (!done) @(negedge clk);
    while (done) begin doneCycles++; @(negedge clk); end
  endtask

  task automatic doWrite(input logic [7:0] d, input logic ack, input string req);
    int dc;
    readMode = 1'b0; tgtAck = ack;
    doCmd(3'd3, d, 1'b0, dc);
    check(shReg == d, {req, " R5 byte seen by target"}, shReg, d);
    check(ackRcvd == !ack, {req, " R6 ackRcvd"}, ackRcvd, !ack);
    check(busy == 1'b0, {req, " R6 idle after byte"}, busy, 0);
  endtask

  task automatic doRead(input logic [7:0] d, input logic last);
    int dc;
    readMode = 1'b1; tgtByte = d;
    doCmd(3'd4, 8'h00, last, dc);
    check(rxData == d, "R7 rxData", rxData, d);
    check(masterAck == last, "R7 ninth-pulse level", masterAck, last);
    readMode = 1'b0;
  endtask

  task automatic doCond(input logic [2:0] op);
    int dc;
    readMode = 1'b0;
    condAllowed = 1'b1;
    doCmd(op, 8'h00, 1'b0, dc);
    condAllowed = 1'b0;
    check(dc == 1, "R9 done width", dc, 1);
  endtask

  initial begin
    int dc;
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclOe == 1'b0, "R1 sclOe", sclOe, 0);
    check(sdaOe == 1'b0, "R1 sdaOe", sdaOe, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0 && ackRcvd == 1'b0, "R1 done/ackRcvd", {done, ackRcvd}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 illegal opcodes
    for (int k = 5; k <= 7; k++) begin
      cmdOp = 3'(k); cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
      @(negedge clk);
      check(busy == 1'b0 && !sclOe && !sdaOe, "R10 illegal op ignored", {busy, sclOe, sdaOe}, 0);
    end
    cmdOp = 3'd0; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && startCnt == 0, "R10 op 0 ignored", busy, 0);

    // R2 START on a free bus
    doCond(3'd1);
    check(startCnt == 1, "R2 start seen", startCnt, 1);
    check(sclOe == 1'b1, "R2 SCL held after start", sclOe, 1);

    doWrite(8'hA5, 1'b1, "ack");
    doWrite(8'h3C, 1'b0, "nack");

    // R3 repeated START after a refused byte
    doCond(3'd1);
    check(startCnt == 2 && stopCnt == 0, "R3 repeated start", {startCnt[3:0], stopCnt[3:0]}, 8'h20);

    // R8 target stretches every low phase
    s0 = stretchEvents;
    stretchLen = 25;
    doWrite(8'h81, 1'b1, "stretch");
    stretchLen = 0;
    @(negedge clk);
    while (tgtSclHold) @(negedge clk);
    check(stretchEvents - s0 >= 9, "R8 stretch exercised", stretchEvents - s0, 9);

    doRead(8'h96, 1'b0);
    doRead(8'h5A, 1'b1);

    // R4 STOP
    doCond(3'd2);
    check(stopCnt == 1, "R4 stop seen", stopCnt, 1);
    check(!sclOe && !sdaOe && sclLine && sdaLine, "R4 lines released",
          {sclOe, sdaOe}, 0);

    // R9 command while busy is ignored; new divider
    cfgDiv = 16'd9;
    doCond(3'd1);
    readMode = 1'b0; tgtAck = 1'b1;
    @(negedge clk);
    cmdOp = 3'd3; cmdData = 8'h42; cmdLast = 1'b0; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R9 busy during byte", busy, 1);
    cmdOp = 3'd2; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    dc = 0;
    while (!done) @(negedge clk);
    while (done) begin dc++; @(negedge clk); end
    check(dc == 1, "R9 done one cycle", dc, 1);
    check(busy == 1'b0, "R9 busy low after done", busy, 0);
    repeat (3 * 9) @(negedge clk);
    check(stopCnt == 1 && sclOe, "R9 STOP while busy ignored", stopCnt, 1);
    check(shReg == 8'h42, "R9 R5 byte intact", shReg, 8'h42);

    doWrite(8'hF0, 1'b1, "div9");
    doWrite(8'h01, 1'b0, "div9 nack");
    doRead(8'hC3, 1'b1);
    doCond(3'd2);
    check(stopCnt == 2, "R4 second stop", stopCnt, 2);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule